// File: doc/BRIEF.md
# Windowed Multi-Phase Current Peak Detector

This block watches the signed current samples of up to three phases and keeps the largest absolute value seen over a measurement window. The window does not last a fixed number of clocks. It lasts a programmable number of half-line cycles, and these are counted from voltage zero-crossing pulses. When a window closes, the block publishes an 8-bit peak code and starts a new search from zero. The peak code is bits 21 down to 14 of the winning magnitude.

Two masks set the sources. One mask picks which current phases take part in the peak search, and any combination of phases may be chosen. The other mask picks which voltage phases supply the zero crossings that advance the window. The published code stays unchanged for the whole of the next window. The host can read it at any time.

Top module: `wpk_peak_detect`

## Requirements
- R1: A synchronous active-high reset clears the published peak code to 0, the running maximum and the half-cycle counter. The code reads 0 until the first window closes after reset.
- R2: The magnitude of a sample is its absolute value. The published code is magnitude bits 21..14. A sample of 0x2851EC or of its negative, 0xD7AE14, yields a code of 0xA1.
- R3: The most negative sample, 0x800000, saturates to a magnitude of 0x7FFFFF, which gives a code of 0xFF.
- R4: A sample takes part only when its valid bit is high and its bit in the current-phase mask is set. Bit 0 is phase A, bit 1 is phase B and bit 2 is phase C. When several bits are set, the largest magnitude among them wins.
- R5: A clock cycle counts as one crossing when it has at least one zero-crossing pulse from a phase selected in the crossing mask (bit 0 is A, bit 1 is B, bit 2 is C). The window closes on the Nth such cycle, where N is the half-cycle count.
- R6: A half-cycle count of 0 acts as 1, so every counted crossing closes a window.
- R7: The published code changes only at a window close. It takes the closed window's peak on the clock after the closing edge and holds it until the next close.
- R8: At a window close, the running maximum restarts from zero. A sample that arrives in the closing cycle counts toward the new window.
- R9: Zero-crossing pulses on phases that are not selected in the crossing mask neither advance the window nor close it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cur_smp | input | 72 | Three signed 24-bit current samples, phase A in bits 23..0 |
| cur_vld | input | 3 | Valid strobe per current phase |
| zc_pulse | input | 3 | Zero-crossing pulse per voltage phase |
| cur_sel | input | 3 | Current phases included in the peak search |
| zc_sel | input | 3 | Voltage phases whose crossings advance the window |
| half_cyc | input | 8 | Half-line cycles per window (0 acts as 1) |
| peak_code | output | 8 | Peak code of the last completed window |

## Verification
The hardest case to reach is a sample that lands in the same clock as the closing zero crossing. It must go into the new window and not into the code being published. The stimulus drives a large sample and the final crossing in the same cycle. It then closes one empty window to show that the sample was carried over, and a second empty window to show that the maximum restarted. Multi-crossing windows are checked partway through to confirm the code has not moved. Pulses on unselected voltage phases are checked the same way.

// File: rtl/wpk_pkg.sv
package wpk_pkg;
  localparam int DEF_SMP_W    = 24;
  localparam int DEF_NPH      = 3;
  localparam int DEF_HC_W     = 8;
  localparam int DEF_CODE_LSB = 14;
  localparam int DEF_CODE_W   = 8;
endpackage

// File: rtl/wpk_mag.sv
module wpk_mag #(
  parameter int SMP_W = wpk_pkg::DEF_SMP_W,
  localparam int MAG_W = SMP_W - 1
) (
  input  logic [SMP_W-1:0] smp,
  input  logic             vld,
  input  logic             en,
  output logic [MAG_W-1:0] mag
);
  logic [SMP_W-1:0] neg;
  logic             is_min;

  always_comb begin
    neg    = (~smp) + {{(SMP_W-1){1'b0}}, 1'b1};
    is_min = (smp == {1'b1, {(SMP_W-1){1'b0}}});
    if (!(vld && en))
      mag = '0;
    else if (is_min)
      mag = '1;
    else if (smp[SMP_W-1])
      mag = neg[MAG_W-1:0];
    else
      mag = smp[MAG_W-1:0];
  end
endmodule

// File: rtl/wpk_zc_win.sv
module wpk_zc_win #(
  parameter int NPH  = wpk_pkg::DEF_NPH,
  parameter int HC_W = wpk_pkg::DEF_HC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NPH-1:0]  zc_pulse,
  input  logic [NPH-1:0]  zc_sel,
  input  logic [HC_W-1:0] half_cyc,
  output logic            win_close,
  output logic [HC_W-1:0] win_cnt
);
  logic            hit;
  logic [HC_W-1:0] tgt;
  logic [HC_W:0]   cnt_nx;

  always_comb begin
    hit       = |(zc_pulse & zc_sel);
    tgt       = (half_cyc == '0) ? {{(HC_W-1){1'b0}}, 1'b1} : half_cyc;
    cnt_nx    = {1'b0, win_cnt} + {{HC_W{1'b0}}, 1'b1};
    win_close = hit && (cnt_nx >= {1'b0, tgt});
  end

  always_ff @(posedge clk) begin
    if (rst)
      win_cnt <= '0;
    else if (win_close)
      win_cnt <= '0;
    else if (hit)
      win_cnt <= cnt_nx[HC_W-1:0];
  end
endmodule

// File: rtl/wpk_track.sv
module wpk_track #(
  parameter int NPH      = wpk_pkg::DEF_NPH,
  parameter int MAG_W    = wpk_pkg::DEF_SMP_W - 1,
  parameter int CODE_LSB = wpk_pkg::DEF_CODE_LSB,
  parameter int CODE_W   = wpk_pkg::DEF_CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPH*MAG_W-1:0] mag_flat,
  input  logic                 win_close,
  output logic [MAG_W-1:0]     run_max,
  output logic [CODE_W-1:0]    peak_code
);
  logic [MAG_W-1:0] cyc_max;
  logic [MAG_W-1:0] grow;

  always_comb begin
    cyc_max = '0;
    for (int i = 0; i < NPH; i++)
      if (mag_flat[i*MAG_W +: MAG_W] > cyc_max)
        cyc_max = mag_flat[i*MAG_W +: MAG_W];
    grow = (cyc_max > run_max) ? cyc_max : run_max;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_max   <= '0;
      peak_code <= '0;
    end else if (win_close) begin
      peak_code <= run_max[CODE_LSB +: CODE_W];
      run_max   <= cyc_max;
    end else begin
      run_max   <= grow;
    end
  end
endmodule

// File: rtl/wpk_peak_detect.sv
module wpk_peak_detect #(
  parameter int SMP_W    = wpk_pkg::DEF_SMP_W,
  parameter int NPH      = wpk_pkg::DEF_NPH,
  parameter int HC_W     = wpk_pkg::DEF_HC_W,
  parameter int CODE_LSB = wpk_pkg::DEF_CODE_LSB,
  parameter int CODE_W   = wpk_pkg::DEF_CODE_W,
  localparam int MAG_W   = SMP_W - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPH*SMP_W-1:0] cur_smp,
  input  logic [NPH-1:0]       cur_vld,
  input  logic [NPH-1:0]       zc_pulse,
  input  logic [NPH-1:0]       cur_sel,
  input  logic [NPH-1:0]       zc_sel,
  input  logic [HC_W-1:0]      half_cyc,
  output logic [CODE_W-1:0]    peak_code
);
  logic [NPH*MAG_W-1:0] mag_flat;
  logic                 win_close;
  logic [HC_W-1:0]      win_cnt;
  logic [MAG_W-1:0]     run_max;

  for (genvar g = 0; g < NPH; g++) begin : g_mag
    wpk_mag #(.SMP_W(SMP_W)) u_mag (
      .smp (cur_smp[g*SMP_W +: SMP_W]),
      .vld (cur_vld[g]),
      .en  (cur_sel[g]),
      .mag (mag_flat[g*MAG_W +: MAG_W])
    );
  end

  wpk_zc_win #(.NPH(NPH), .HC_W(HC_W)) u_win (
    .clk       (clk),
    .rst       (rst),
    .zc_pulse  (zc_pulse),
    .zc_sel    (zc_sel),
    .half_cyc  (half_cyc),
    .win_close (win_close),
    .win_cnt   (win_cnt)
  );

  wpk_track #(.NPH(NPH), .MAG_W(MAG_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W)) u_trk (
    .clk       (clk),
    .rst       (rst),
    .mag_flat  (mag_flat),
    .win_close (win_close),
    .run_max   (run_max),
    .peak_code (peak_code)
  );
endmodule

// File: rtl/wpk_peak_chk.sv
module wpk_peak_chk #(
  parameter int NPH      = 3,
  parameter int HC_W     = 8,
  parameter int MAG_W    = 23,
  parameter int CODE_LSB = 14,
  parameter int CODE_W   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [NPH-1:0]    zc_pulse,
  input logic [NPH-1:0]    zc_sel,
  input logic              win_close,
  input logic [HC_W-1:0]   win_cnt,
  input logic [MAG_W-1:0]  run_max,
  input logic [CODE_W-1:0] peak_code
);
  logic armed;
  logic rst_d;

  always_ff @(posedge clk) begin
    armed <= !rst;
    rst_d <= rst;
    if (rst_d)
      p_reset_clear_r1: assert (peak_code == '0);
  end

  p_publish_r7: assert property (@(posedge clk) disable iff (rst)
    armed && $past(win_close) |-> peak_code == $past(run_max[CODE_LSB +: CODE_W]));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(win_close) |-> $stable(peak_code));

  p_max_grow_r8: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(win_close) |-> run_max >= $past(run_max));

  p_close_needs_zc_r9: assert property (@(posedge clk) disable iff (rst)
    win_close |-> |(zc_pulse & zc_sel));

  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    armed && $past(|(zc_pulse & zc_sel)) && !$past(win_close)
      |-> win_cnt == $past(win_cnt) + {{(HC_W-1){1'b0}}, 1'b1});

  p_idle_count_r5: assert property (@(posedge clk) disable iff (rst)
    armed && !$past(|(zc_pulse & zc_sel)) |-> $stable(win_cnt));
endmodule

bind wpk_peak_detect wpk_peak_chk #(
  .NPH(NPH), .HC_W(HC_W), .MAG_W(MAG_W), .CODE_LSB(CODE_LSB), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .zc_pulse(zc_pulse), .zc_sel(zc_sel),
  .win_close(win_close), .win_cnt(win_cnt), .run_max(run_max), .peak_code(peak_code)
);

// File: tb/sim_wpk_peak_detect.sv
module sim_wpk_peak_detect;
  logic        clk = 0;
  logic        rst = 1;
  logic [71:0] cur_smp = '0;
  logic [2:0]  cur_vld = '0, zc_pulse = '0, cur_sel = '0, zc_sel = '0;
  logic [7:0]  half_cyc = '0;
  logic [7:0]  peak_code;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  wpk_peak_detect u0 (.clk(clk), .rst(rst), .cur_smp(cur_smp), .cur_vld(cur_vld),
    .zc_pulse(zc_pulse), .cur_sel(cur_sel), .zc_sel(zc_sel), .half_cyc(half_cyc),
    .peak_code(peak_code));

  typedef struct packed {
    logic [23:0] a, b, c;
    logic [2:0]  sel;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{24'h2851EC, 24'h0,      24'h0,      3'b001, 8'hA1},  // R2
    '{24'hD7AE14, 24'h0,      24'h0,      3'b001, 8'hA1},  // R2 negative
    '{24'h010000, 24'h200000, 24'h0C0000, 3'b011, 8'h80},  // R4
    '{24'h010000, 24'h200000, 24'h0C0000, 3'b101, 8'h30},  // R4
    '{24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 3'b000, 8'h00},  // R4 none selected
    '{24'h800000, 24'h0,      24'h0,      3'b001, 8'hFF},  // R3
    '{24'h003FFF, 24'hFF8000, 24'h7FFFFF, 3'b011, 8'h02}   // R2/R4
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: peak_code=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c,
                      input logic [2:0] vld, input logic [2:0] zc);
    cur_smp  = {c, b, a};
    cur_vld  = vld;
    zc_pulse = zc;
    @(negedge clk);
  endtask

  task automatic idle();
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(); idle();
    check("R1 reset state", peak_code, 8'h00);
    rst = 0;
    zc_sel = 3'b001; half_cyc = 8'd1;
    idle();
    check("R1 before first window", peak_code, 8'h00);

    for (int i = 0; i < 7; i++) begin
      cur_sel = VECS[i].sel;
      step(VECS[i].a, VECS[i].b, VECS[i].c, 3'b111, 3'b000);
      step(24'h0, 24'h0, 24'h0, 3'b000, 3'b001);
      check($sformatf("R2/R3/R4 vector %0d", i), peak_code, VECS[i].exp);
    end

    // R4: valid low ignored
    cur_sel = 3'b111;
    step(24'h7FFFFF, 24'h7FFFFF, 24'h7FFFFF, 3'b000, 3'b000);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b001);
    check("R4 invalid sample ignored", peak_code, 8'h00);

    // R6: count zero acts as one
    half_cyc = 8'd0;
    step(24'h140000, 24'h0, 24'h0, 3'b001, 3'b000);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b001);
    check("R6 zero count closes each crossing", peak_code, 8'h50);

    // R5/R7: three crossings per window, code holds until the third
    half_cyc = 8'd3;
    step(24'h100000, 24'h0, 24'h0, 3'b001, 3'b000);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b001);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b001);
    check("R5 window open after two crossings", peak_code, 8'h50);
    step(24'h0, 24'h3C0000, 24'h0, 3'b010, 3'b000);
    check("R7 code holds mid-window", peak_code, 8'h50);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b111);
    check("R5 close on third crossing", peak_code, 8'hF0);

    // R9: unselected crossings ignored
    half_cyc = 8'd1; zc_sel = 3'b010;
    step(24'h040000, 24'h0, 24'h0, 3'b001, 3'b101);
    idle();
    check("R9 unselected crossing ignored", peak_code, 8'hF0);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b010);
    check("R9 selected crossing closes", peak_code, 8'h10);

    // R8: sample on closing cycle belongs to new window, then restart
    step(24'h200000, 24'h0, 24'h0, 3'b001, 3'b000);
    step(24'h300000, 24'h0, 24'h0, 3'b001, 3'b010);
    check("R8 closing sample excluded", peak_code, 8'h80);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b010);
    check("R8 closing sample carried", peak_code, 8'hC0);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b010);
    check("R8 maximum restarted", peak_code, 8'h00);

    // R7: L1, L2, L1 sequence
    step(24'h080000, 24'h0, 24'h0, 3'b001, 3'b010);
    step(24'h180000, 24'h0, 24'h0, 3'b001, 3'b010);
    check("R7 first L1", peak_code, 8'h20);
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b010);
    check("R7 L2", peak_code, 8'h60);

    // R1: reset mid-window clears everything
    step(24'h7FFFFF, 24'h0, 24'h0, 3'b001, 3'b000);
    rst = 1;
    idle();
    check("R1 reset clears code", peak_code, 8'h00);
    rst = 0;
    step(24'h0, 24'h0, 24'h0, 3'b000, 3'b010);
    check("R1 reset cleared running max", peak_code, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule